// File: doc/BRIEF.md
# Hall Sensor State Decoder

This block reads the three phase outputs of a Hall-effect rotor sensor and turns each move between neighbouring commutation states into a counting event. The three inputs are treated as one 3-bit code with phase C in bit 2, B in bit 1 and A in bit 0. Every new legal code is compared with the last accepted legal code. A move one place forward in the fixed six-state cycle counts up. A move one place backward counts down. A one-cycle pulse and a direction bit report each move, and a signed position counter follows them.

The two codes that a healthy sensor never produces, all-zeros and all-ones, set a sticky error flag. This flag raises an interrupt line only while its enable input is high. Decoding takes place only while the Hall mode enable is high and the 2-bit counting-mode select is zero. The inputs are asynchronous to the clock and pass through a two-stage synchronizer first.

Top module: `hall_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `position` = 0, `countPulse` = 0, `errFlag` = 0, `errIrq` = 0 and `hallState` = 3'b000. Reset is synchronous.
- R2: A change from the last accepted state to its forward neighbour produces `countPulse` = 1 with `countDir` = 1, and `position` goes up by one. The forward cycle is 100→101→001→011→010→110→100 in C-B-A order. The results show after the third rising edge that samples the new input.
- R3: A change to the backward neighbour, following the cycle 100→110→010→011→001→101→100, produces `countPulse` = 1 with `countDir` = 0, and `position` goes down by one.
- R4: `countPulse` is high for exactly one cycle per accepted move. While the input code stays the same it remains low and `position` holds.
- R5: The first legal code seen after reset, or after decoding is re-enabled, becomes `hallState` without a pulse and without a change of `position`.
- R6: A change between two legal codes that are not neighbours (for example 100→011) gives no pulse and leaves `position` unchanged, but `hallState` takes the new code.
- R7: Codes 3'b000 and 3'b111 set `errFlag`, which stays set. They never change `hallState` or `position`, and `hallState` never holds 3'b111.
- R8: A high `errClr` at a rising edge clears `errFlag`, unless an illegal code is decoded at the same edge, in which case the flag stays set.
- R9: `errIrq` is high exactly when `errFlag` and `errIrqEn` are both high.
- R10: Decoding needs `hallModeEn` = 1 and `countMode` = 2'b00. In any other setting the block makes no pulse, does not set `errFlag` and does not count.
- R11: A high `posLoad` at a rising edge loads `posLoadVal` into `position`, even when a count happens at the same edge. Counting wraps in two's complement (0x7FFFFFFF+1 = 0x80000000, 0−1 = 0xFFFFFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hallIn | input | 3 | Raw Hall phases: bit 2 = C, bit 1 = B, bit 0 = A |
| hallModeEn | input | 1 | Hall mode enable |
| countMode | input | 2 | Counting-mode select; Hall decoding only at 2'b00 |
| errIrqEn | input | 1 | Interrupt enable for the state error |
| errClr | input | 1 | Write-one-to-clear strobe for the error flag |
| posLoad | input | 1 | Load strobe for the position counter |
| posLoadVal | input | 32 | Value to load into the position counter |
| countPulse | output | 1 | One-cycle pulse per accepted state move |
| countDir | output | 1 | Direction of the last move: 1 = forward, 0 = backward |
| hallState | output | 3 | Last accepted legal state, C-B-A order |
| errFlag | output | 1 | Sticky illegal-code flag |
| errIrq | output | 1 | Error interrupt request |
| position | output | 32 | Signed position count |

## Verification
A new `hallIn` value passes two synchronizer flops and reaches the decode register at the third rising edge. The pulse, direction, accepted state, error flag and counter change together at that edge. The bench therefore drives each code on a falling edge, waits three rising edges and compares on the next falling edge. It then waits one more cycle to confirm the pulse has dropped. Loads, clears and mode changes reach registers directly at the next edge and are checked one cycle later. Before any code changes, `hallIn` is held for three cycles after each mode change, so the bench model only ever sees a fully settled input.

// File: rtl/hall_pkg.sv
package hall_pkg;

  localparam int unsigned HALL_W = 3;

  typedef logic [HALL_W-1:0] hall_code_t;

  // Strobes from decode control to the position/flag datapath.
  typedef struct packed {
    logic countEn;
    logic countUp;
    logic errSet;
  } hall_strobe_t;

  function automatic logic isLegal(input hall_code_t code);
    return (code != 3'b000) && (code != 3'b111);
  endfunction

  // Forward neighbour in the commutation cycle.
  function automatic hall_code_t fwdNext(input hall_code_t code);
    case (code)
      3'b100:  return 3'b101;
      3'b101:  return 3'b001;
      3'b001:  return 3'b011;
      3'b011:  return 3'b010;
      3'b010:  return 3'b110;
      3'b110:  return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // Backward neighbour in the commutation cycle.
  function automatic hall_code_t bwdNext(input hall_code_t code);
    case (code)
      3'b100:  return 3'b110;
      3'b110:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b001;
      3'b001:  return 3'b101;
      3'b101:  return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             primed
);

  logic [WIDTH-1:0] stageQ [STAGES];
  logic [STAGES-1:0] fillQ;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        stageQ[g] <= din;
        if (rst) fillQ[g] <= 1'b0;
        else     fillQ[g] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        stageQ[g] <= stageQ[g-1];
        if (rst) fillQ[g] <= 1'b0;
        else     fillQ[g] <= fillQ[g-1];
      end
    end
  end

  assign dout   = stageQ[STAGES-1];
  assign primed = fillQ[STAGES-1];

endmodule

// File: rtl/hall_ctrl.sv
module hall_ctrl
  import hall_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  hall_code_t   curCode,
  input  logic         decodeOn,
  output hall_strobe_t strobe,
  output hall_code_t   prevState,
  output logic         countPulse,
  output logic         countDir
);

  logic curLegal;
  logic prevValid;

  assign curLegal = isLegal(curCode);

  always_comb begin
    strobe = '0;
    if (decodeOn) begin
      if (!curLegal) begin
        strobe.errSet = 1'b1;
      end else if (prevValid && (curCode != prevState)) begin
        if (curCode == fwdNext(prevState)) begin
          strobe.countEn = 1'b1;
          strobe.countUp = 1'b1;
        end else if (curCode == bwdNext(prevState)) begin
          strobe.countEn = 1'b1;
          strobe.countUp = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevState  <= '0;
      prevValid  <= 1'b0;
      countPulse <= 1'b0;
      countDir   <= 1'b0;
    end else begin
      countPulse <= strobe.countEn;
      if (strobe.countEn) countDir <= strobe.countUp;
      if (!decodeOn) begin
        prevValid <= 1'b0;
      end else if (curLegal) begin
        prevState <= curCode;
        prevValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hall_datapath.sv
module hall_datapath
  import hall_pkg::*;
#(
  parameter int unsigned POS_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  hall_strobe_t            strobe,
  input  logic                    errClr,
  input  logic                    errIrqEn,
  input  logic                    posLoad,
  input  logic signed [POS_W-1:0] posLoadVal,
  output logic signed [POS_W-1:0] position,
  output logic                    errFlag,
  output logic                    errIrq
);

  localparam logic signed [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      position <= '0;
    end else if (posLoad) begin
      position <= posLoadVal;
    end else if (strobe.countEn) begin
      position <= strobe.countUp ? position + ONE : position - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                errFlag <= 1'b0;
    else if (strobe.errSet) errFlag <= 1'b1;
    else if (errClr)        errFlag <= 1'b0;
  end

  assign errIrq = errFlag & errIrqEn;

endmodule

// File: rtl/hall_decoder.sv
module hall_decoder
  import hall_pkg::*;
#(
  parameter int unsigned POS_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              hallIn,
  input  logic                    hallModeEn,
  input  logic [1:0]              countMode,
  input  logic                    errIrqEn,
  input  logic                    errClr,
  input  logic                    posLoad,
  input  logic signed [POS_W-1:0] posLoadVal,
  output logic                    countPulse,
  output logic                    countDir,
  output logic [2:0]              hallState,
  output logic                    errFlag,
  output logic                    errIrq,
  output logic signed [POS_W-1:0] position
);

  localparam logic [1:0] HALL_MODE_SEL = 2'b00;

  hall_code_t   syncCode;
  logic         syncPrimed;
  logic         decodeOn;
  hall_strobe_t strobe;

  hall_sync #(.WIDTH(HALL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (hallIn),
    .dout   (syncCode),
    .primed (syncPrimed)
  );

  assign decodeOn = syncPrimed && hallModeEn && (countMode == HALL_MODE_SEL);

  hall_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .curCode    (syncCode),
    .decodeOn   (decodeOn),
    .strobe     (strobe),
    .prevState  (hallState),
    .countPulse (countPulse),
    .countDir   (countDir)
  );

  hall_datapath #(.POS_W(POS_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .errClr     (errClr),
    .errIrqEn   (errIrqEn),
    .posLoad    (posLoad),
    .posLoadVal (posLoadVal),
    .position   (position),
    .errFlag    (errFlag),
    .errIrq     (errIrq)
  );

endmodule

// File: rtl/hall_decoder_chk.sv
module hall_decoder_chk #(
  parameter int unsigned POS_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    hallModeEn,
  input logic [1:0]              countMode,
  input logic                    errIrqEn,
  input logic                    errClr,
  input logic                    posLoad,
  input logic signed [POS_W-1:0] posLoadVal,
  input logic                    countPulse,
  input logic                    countDir,
  input logic [2:0]              hallState,
  input logic                    errFlag,
  input logic                    errIrq,
  input logic signed [POS_W-1:0] position
);

  a_r2_fwd_step: assert property (@(posedge clk) disable iff (rst)
    (countPulse && countDir && !$past(posLoad) && !$past(rst))
      |-> (position == POS_W'($past(position) + 1)));

  a_r3_bwd_step: assert property (@(posedge clk) disable iff (rst)
    (countPulse && !countDir && !$past(posLoad) && !$past(rst))
      |-> (position == POS_W'($past(position) - 1)));

  a_r7_sticky_err: assert property (@(posedge clk) disable iff (rst)
    ($past(errFlag) && !$past(errClr) && !$past(rst)) |-> errFlag);

  a_r7_state_legal: assert property (@(posedge clk) disable iff (rst)
    hallState != 3'b111);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    errIrq |-> (errFlag && errIrqEn));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(hallModeEn) && ($past(countMode) == 2'b00)))
      |-> (!countPulse && ($past(errFlag) || !errFlag)));

  a_r11_load: assert property (@(posedge clk) disable iff (rst)
    ($past(posLoad) && !$past(rst)) |-> (position == $past(posLoadVal)));

endmodule

bind hall_decoder hall_decoder_chk #(.POS_W(POS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hallModeEn (hallModeEn),
  .countMode  (countMode),
  .errIrqEn   (errIrqEn),
  .errClr     (errClr),
  .posLoad    (posLoad),
  .posLoadVal (posLoadVal),
  .countPulse (countPulse),
  .countDir   (countDir),
  .hallState  (hallState),
  .errFlag    (errFlag),
  .errIrq     (errIrq),
  .position   (position)
);

// File: tb/hall_decoder_tb.sv
module hall_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  hallIn = 3'b100;
  logic        hallModeEn = 1'b1;
  logic [1:0]  countMode = 2'b00;
  logic        errIrqEn = 1'b0;
  logic        errClr = 1'b0;
  logic        posLoad = 1'b0;
  logic [31:0] posLoadVal = '0;
  logic        countPulse, countDir, errFlag, errIrq;
  logic [2:0]  hallState;
  logic [31:0] position;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Bench model state
  logic [2:0]  curCode = 3'b100;
  logic [2:0]  expPrev = 3'b000;
  bit          expValid = 1'b0;
  logic [31:0] expPos = '0;
  bit          expErr = 1'b0;
  bit          expPulse, expDir;

  always #5 clk = ~clk;

  hall_decoder u_dut (
    .clk(clk), .rst(rst), .hallIn(hallIn), .hallModeEn(hallModeEn),
    .countMode(countMode), .errIrqEn(errIrqEn), .errClr(errClr),
    .posLoad(posLoad), .posLoadVal(posLoadVal), .countPulse(countPulse),
    .countDir(countDir), .hallState(hallState), .errFlag(errFlag),
    .errIrq(errIrq), .position(position)
  );

  function automatic logic [2:0] fwdOf(input logic [2:0] c);
    case (c)
      3'b100: return 3'b101; 3'b101: return 3'b001; 3'b001: return 3'b011;
      3'b011: return 3'b010; 3'b010: return 3'b110; 3'b110: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] bwdOf(input logic [2:0] c);
    case (c)
      3'b100: return 3'b110; 3'b110: return 3'b010; 3'b010: return 3'b011;
      3'b011: return 3'b001; 3'b001: return 3'b101; 3'b101: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic bit legalOf(input logic [2:0] c);
    return (c != 3'b000) && (c != 3'b111);
  endfunction

  function automatic bit modeOn();
    return hallModeEn && (countMode == 2'b00);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Model of one settled decode of curCode.
  task automatic applyModel();
    expPulse = 1'b0;
    if (!modeOn()) begin
      expValid = 1'b0;
    end else if (!legalOf(curCode)) begin
      expErr = 1'b1;
    end else if (!expValid) begin
      expPrev = curCode; expValid = 1'b1;
    end else if (curCode != expPrev) begin
      if (curCode == fwdOf(expPrev)) begin
        expPulse = 1'b1; expDir = 1'b1; expPos = expPos + 1;
      end else if (curCode == bwdOf(expPrev)) begin
        expPulse = 1'b1; expDir = 1'b0; expPos = expPos - 1;
      end
      expPrev = curCode;
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "countPulse", {31'b0, countPulse}, {31'b0, expPulse});
    if (expPulse) check(tag, "countDir", {31'b0, countDir}, {31'b0, expDir});
    check(tag, "position", position, expPos);
    check(tag, "hallState", {29'b0, hallState}, {29'b0, expPrev});
    check("R7", "errFlag", {31'b0, errFlag}, {31'b0, expErr});
    check("R9", "errIrq", {31'b0, errIrq}, {31'b0, expErr & errIrqEn});
  endtask

  task automatic step(input logic [2:0] code, input bit ien, input string tag);
    @(negedge clk);
    hallIn = code; errIrqEn = ien; curCode = code;
    repeat (3) @(posedge clk);
    @(negedge clk);
    applyModel();
    checkAll(tag);
    @(negedge clk);
    check("R4", "pulse drop", {31'b0, countPulse}, 32'd0);
  endtask

  task automatic setMode(input bit en, input logic [1:0] sel, input string tag);
    @(negedge clk);
    hallModeEn = en; countMode = sel;
    repeat (3) @(posedge clk);
    @(negedge clk);
    applyModel();
    checkAll(tag);
  endtask

  task automatic clearErr();
    @(negedge clk);
    errClr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    errClr = 1'b0;
    expErr = modeOn() && !legalOf(curCode);
    check("R8", "errFlag after clear", {31'b0, errFlag}, {31'b0, expErr});
  endtask

  task automatic loadPos(input logic [31:0] val);
    @(negedge clk);
    posLoad = 1'b1; posLoadVal = val;
    @(posedge clk);
    @(negedge clk);
    posLoad = 1'b0;
    expPos = val;
    check("R11", "position after load", position, expPos);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset position", position, 32'd0);
    check("R1", "reset pulse", {31'b0, countPulse}, 32'd0);
    check("R1", "reset errFlag", {31'b0, errFlag}, 32'd0);
    check("R1", "reset errIrq", {31'b0, errIrq}, 32'd0);
    check("R1", "reset hallState", {29'b0, hallState}, 32'd0);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    applyModel();
    checkAll("R5");

    // R2: full forward revolution
    for (int i = 0; i < 6; i++) step(fwdOf(curCode), 1'b0, "R2");
    check("R2", "position after revolution", position, 32'd6);
    step(curCode, 1'b0, "R4");
    // R3: full backward revolution
    for (int i = 0; i < 6; i++) step(bwdOf(curCode), 1'b0, "R3");
    check("R3", "position after revolution", position, 32'd0);
    // R6: jump to the opposite state
    step(3'b011, 1'b0, "R6");
    // R7 / R9: illegal codes
    step(3'b000, 1'b1, "R7");
    step(3'b111, 1'b0, "R7");
    step(3'b011, 1'b1, "R7");
    clearErr();
    step(3'b000, 1'b1, "R8");
    clearErr();
    step(3'b011, 1'b0, "R8");
    clearErr();
    // R10: other modes
    setMode(1'b0, 2'b00, "R10");
    step(3'b010, 1'b0, "R10");
    setMode(1'b1, 2'b01, "R10");
    step(3'b111, 1'b1, "R10");
    step(3'b010, 1'b0, "R10");
    setMode(1'b1, 2'b00, "R5");
    step(3'b110, 1'b0, "R2");
    // R11: load and wrap
    loadPos(32'h7FFF_FFFF);
    step(fwdOf(curCode), 1'b0, "R11");
    check("R11", "wrap up", position, 32'h8000_0000);
    loadPos(32'h0000_0000);
    step(bwdOf(curCode), 1'b0, "R11");
    check("R11", "wrap down", position, 32'hFFFF_FFFF);
    // R11: load wins over a count in the same edge
    @(negedge clk);
    curCode = fwdOf(curCode); hallIn = curCode;
    repeat (2) @(posedge clk);
    @(negedge clk);
    posLoad = 1'b1; posLoadVal = 32'h0000_1234;
    @(posedge clk);
    @(negedge clk);
    posLoad = 1'b0;
    applyModel();
    expPos = 32'h0000_1234;
    check("R11", "load beats count", position, expPos);
    check("R2", "pulse with load", {31'b0, countPulse}, 32'd1);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned pick = $urandom % 100;
      if (pick < 4) begin
        setMode(($urandom % 4) != 0, (($urandom % 2) != 0) ? 2'($urandom) : 2'b00, "R10");
      end else if (pick < 8) begin
        clearErr();
      end else if (pick < 10) begin
        loadPos($urandom);
      end else if (pick < 55) begin
        step(legalOf(curCode) ? fwdOf(curCode) : 3'b001, 1'($urandom), "R2");
      end else if (pick < 80) begin
        step(legalOf(curCode) ? bwdOf(curCode) : 3'b100, 1'($urandom), "R3");
      end else begin
        step(3'($urandom), 1'($urandom), "R6");
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule